// File: doc/BRIEF.md
# Warp Lane Shuffle Exchange Unit

This block lets every lane of a 32-lane group read a word held by another lane of the same group in one operation. No shared storage is involved. Each lane supplies its own select operand, which the current mode reads as a lane number, a shift distance or an XOR mask. A shared bound operand limits which source lanes count as valid. Each lane also gets a predicate bit that shows whether its source lane was in range. When the source is not in range, the lane keeps its own word.

A fifth mode merges a per-lane vote bit from every lane into a ballot word. It then broadcasts, to all lanes, the word of the highest-numbered lane that voted true. Words wider than 32 bits are cut into 32-bit slices. Every slice follows the same source lane, so a 64-bit value moves as a unit.

The operation is captured on a valid strobe. Results, predicates and a valid flag appear on the next clock.

Top module: `warp_shuffle_unit`

## Requirements
- R1: Mode code 0 (indexed): lane i receives the word of lane s, where s is lane i's select operand. The predicate is 1 exactly when s <= bound.
- R2: In indexed mode any number of lanes may name the same source lane. With every select at 0, all lanes receive lane 0's word with predicate 1.
- R3: Mode code 1 (shift up): lane i receives the word of lane i-n, where n is its select operand. The predicate is 1 exactly when i >= n and i-n >= bound. A bound of 0 opens the whole group.
- R4: Mode code 2 (shift down): lane i receives the word of lane i+n, with the sum taken without wrap. The predicate is 1 exactly when i+n <= bound. A bound of 31 opens the whole group.
- R5: Mode code 3 (butterfly): lane i receives the word of lane i XOR m, where m is its select operand. The predicate is 1 exactly when (i XOR m) <= bound.
- R6: Mode code 4 (last-true broadcast): when the vote word (bit k = lane k's vote) is nonzero, every lane receives the word of the highest lane with a set vote bit, with predicate 1. When the vote word is zero, no lane has a source.
- R7: A lane with no valid source outputs its own input word with predicate 0. Mode codes 5, 6 and 7 give no lane a source.
- R8: A word is DW bits wide, lane l at bits [l*DW +: DW], and is cut into 32-bit slices. Every slice of a lane's result comes from the same source lane.
- R9: Inputs are taken only in a cycle with in_valid high. out_valid is high in the cycle after each such cycle and low otherwise. Results and predicates hold until the next accepted operation.
- R10: After reset, out_valid, every predicate and every result bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_mode | input | 3 | Addressing mode code |
| in_data | input | LANES*DW | Lane words, lane l at [l*DW +: DW] |
| in_sel | input | LANES*LW | Per-lane index, distance or mask |
| in_bound | input | LW | Range limit shared by all lanes |
| in_vote | input | LANES | Per-lane vote bits for the broadcast mode |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_data | output | LANES*DW | Per-lane results |
| out_pred | output | LANES | Per-lane source-in-range predicate |

## Verification
The bench builds the unit with 32 lanes and a 64-bit word, so each lane result is made of two slices. This exposes any slice that takes its source lane independently of the other. Directed operations cover broadcast from lane 0, bounds at both ends of the group, shifts past the group edges, an empty vote word, a single vote at lane 31 and the unused mode codes. Random operations then mix all codes, selects and bounds against a reference model kept in the bench.

// File: rtl/shfl_pkg.sv
// Shared definitions for the lane shuffle unit.
// Assumes the mode field is three bits wide; codes not listed mean "no source".
package shfl_pkg;
    typedef enum logic [2:0] {
        SH_IDX  = 3'd0,
        SH_UP   = 3'd1,
        SH_DOWN = 3'd2,
        SH_XOR  = 3'd3,
        SH_LAST = 3'd4,
        SH_NONE = 3'd7
    } shfl_mode_e;
endpackage

// File: rtl/shfl_lane_route.sv
// Works out, for one lane, which lane to read and whether that source is in range.
// Assumes LANES is a power of two. An out-of-range source is replaced by the lane itself.
module shfl_lane_route
    import shfl_pkg::*;
#(
    parameter int LANES   = 32,
    parameter int LANE_ID = 0,
    localparam int LW     = $clog2(LANES)
) (
    input  logic [2:0]    mode,
    input  logic [LW-1:0] sel,
    input  logic [LW-1:0] bound,
    input  logic [LW-1:0] last_idx,
    input  logic          last_hit,
    output logic [LW-1:0] src_o,
    output logic          ok_o
);
    logic [LW:0] me;
    logic [LW:0] s_w;
    logic [LW:0] b_w;
    logic [LW:0] raw;

    // Compute the raw source lane and its range check for the selected mode.
    always_comb begin
        me  = (LW+1)'(LANE_ID);
        s_w = {1'b0, sel};
        b_w = {1'b0, bound};
        raw = me;
        ok_o = 1'b0;
        case (mode)
            SH_IDX: begin
                raw  = s_w;
                ok_o = (s_w <= b_w);
            end
            SH_UP: begin
                raw  = me - s_w;
                ok_o = (me >= s_w) && (raw >= b_w);
            end
            SH_DOWN: begin
                raw  = me + s_w;
                ok_o = (raw <= b_w);
            end
            SH_XOR: begin
                raw  = me ^ s_w;
                ok_o = (raw <= b_w);
            end
            SH_LAST: begin
                raw  = {1'b0, last_idx};
                ok_o = last_hit;
            end
            default: begin
                raw  = me;
                ok_o = 1'b0;
            end
        endcase
        src_o = ok_o ? raw[LW-1:0] : me[LW-1:0];
    end
endmodule

// File: rtl/shfl_vote_msb.sv
// Finds the highest set bit of the ballot word and flags whether any bit is set.
// Assumes LANES is a power of two; the result index is LW bits wide.
module shfl_vote_msb #(
    parameter int LANES = 32,
    localparam int LW   = $clog2(LANES)
) (
    input  logic [LANES-1:0] vote,
    output logic [LW-1:0]    idx,
    output logic             hit
);
    // Scan upward so that the last set bit seen is the highest one.
    always_comb begin
        idx = '0;
        hit = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            if (vote[k]) begin
                idx = LW'(k);
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/shfl_slice_xbar.sv
// One slice-wide crossbar: each lane output takes the slice of its chosen source lane.
// Assumes the source vector already holds in-range lane numbers.
module shfl_slice_xbar #(
    parameter int LANES = 32,
    parameter int SW    = 32,
    localparam int LW   = $clog2(LANES)
) (
    input  logic [LANES*SW-1:0] din,
    input  logic [LANES*LW-1:0] src,
    output logic [LANES*SW-1:0] dout
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Select the source lane's slice for lane l.
        assign dout[l*SW +: SW] = din[src[l*LW +: LW]*SW +: SW];
    end
endmodule

// File: rtl/warp_shuffle_unit.sv
// Lane shuffle exchange: registers one operation on a strobe, then routes words
// between lanes in indexed, shift-up, shift-down, butterfly or last-true broadcast mode.
// Assumes LANES is a power of two and DW is a multiple of SLICE_W.
module warp_shuffle_unit
    import shfl_pkg::*;
#(
    parameter int LANES   = 32,
    parameter int DW      = 32,
    parameter int SLICE_W = 32,
    localparam int LW     = $clog2(LANES),
    localparam int NSL    = DW / SLICE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2:0]          in_mode,
    input  logic [LANES*DW-1:0] in_data,
    input  logic [LANES*LW-1:0] in_sel,
    input  logic [LW-1:0]       in_bound,
    input  logic [LANES-1:0]    in_vote,
    output logic                out_valid,
    output logic [LANES*DW-1:0] out_data,
    output logic [LANES-1:0]    out_pred
);
    logic                vld_q;
    logic [2:0]          mode_q;
    logic [LANES*DW-1:0] data_q;
    logic [LANES*LW-1:0] sel_q;
    logic [LW-1:0]       bound_q;
    logic [LANES-1:0]    vote_q;

    logic [LW-1:0]       last_idx;
    logic                last_hit;
    logic [LANES*LW-1:0] src_all;

    // Capture an operation on the strobe; reset to the no-source mode so outputs read 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= 1'b0;
            mode_q  <= SH_NONE;
            data_q  <= '0;
            sel_q   <= '0;
            bound_q <= '0;
            vote_q  <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                mode_q  <= in_mode;
                data_q  <= in_data;
                sel_q   <= in_sel;
                bound_q <= in_bound;
                vote_q  <= in_vote;
            end
        end
    end

    assign out_valid = vld_q;

    shfl_vote_msb #(.LANES(LANES)) i_vote (
        .vote (vote_q),
        .idx  (last_idx),
        .hit  (last_hit)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_route
        shfl_lane_route #(.LANES(LANES), .LANE_ID(l)) i_route (
            .mode     (mode_q),
            .sel      (sel_q[l*LW +: LW]),
            .bound    (bound_q),
            .last_idx (last_idx),
            .last_hit (last_hit),
            .src_o    (src_all[l*LW +: LW]),
            .ok_o     (out_pred[l])
        );
    end

    for (genvar s = 0; s < NSL; s++) begin : g_slice
        logic [LANES*SLICE_W-1:0] sl_in;
        logic [LANES*SLICE_W-1:0] sl_out;
        for (genvar l = 0; l < LANES; l++) begin : g_pack
            // Gather slice s of every lane, then scatter the routed slice back.
            assign sl_in[l*SLICE_W +: SLICE_W]            = data_q[l*DW + s*SLICE_W +: SLICE_W];
            assign out_data[l*DW + s*SLICE_W +: SLICE_W]  = sl_out[l*SLICE_W +: SLICE_W];
        end
        shfl_slice_xbar #(.LANES(LANES), .SW(SLICE_W)) i_xbar (
            .din  (sl_in),
            .src  (src_all),
            .dout (sl_out)
        );
    end

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_pred))); // R9
    AST_LAST_IS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SH_LAST && last_hit) |-> ((vote_q >> last_idx) == LANES'(1))); // R6

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        AST_MISS_KEEPS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
            !out_pred[l] |-> (out_data[l*DW +: DW] == data_q[l*DW +: DW])); // R7
        AST_UP_NOT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q == SH_UP && out_pred[l]) |-> (sel_q[l*LW +: LW] <= LW'(l))); // R3
    end
endmodule

// File: tb/test_warp_shuffle_unit.sv
module test_warp_shuffle_unit;
    localparam int LANES = 32;
    localparam int DW    = 64;
    localparam int LW    = 5;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic [2:0]          in_mode = 3'd0;
    logic [LANES*DW-1:0] in_data = '0;
    logic [LANES*LW-1:0] in_sel = '0;
    logic [LW-1:0]       in_bound = '0;
    logic [LANES-1:0]    in_vote = '0;
    logic                out_valid;
    logic [LANES*DW-1:0] out_data;
    logic [LANES-1:0]    out_pred;

    int checks = 0;
    int errors = 0;
    logic [LANES*DW-1:0] exp_data;
    logic [LANES-1:0]    exp_pred;

    always #2 clk = ~clk;

    warp_shuffle_unit #(.LANES(LANES), .DW(DW), .SLICE_W(32)) i_warp_shuffle_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_data(in_data), .in_sel(in_sel), .in_bound(in_bound), .in_vote(in_vote),
        .out_valid(out_valid), .out_data(out_data), .out_pred(out_pred)
    );

    // Reference model built from the requirements.
    task automatic model();
        int top;
        top = -1;
        for (int k = 0; k < LANES; k++) if (in_vote[k]) top = k;
        for (int l = 0; l < LANES; l++) begin
            int s, b, src;
            bit ok;
            s = int'(in_sel[l*LW +: LW]);
            b = int'(in_bound);
            src = l;
            ok = 1'b0;
            case (in_mode)
                3'd0: begin src = s; ok = (s <= b); end
                3'd1: begin src = l - s; ok = (l >= s) && (l - s >= b); end
                3'd2: begin src = l + s; ok = (l + s <= b); end
                3'd3: begin src = l ^ s; ok = ((l ^ s) <= b); end
                3'd4: begin src = top; ok = (top >= 0); end
                default: ok = 1'b0;
            endcase
            if (!ok) src = l;
            exp_data[l*DW +: DW] = in_data[src*DW +: DW];
            exp_pred[l] = ok;
        end
    endtask

    task automatic compare(string req);
        bit bad;
        bad = 1'b0;
        checks++;
        if (out_valid !== 1'b1) begin
            errors++; bad = 1'b1;
            $display("FAIL %s out_valid %b exp 1", req, out_valid);
        end
        for (int l = 0; l < LANES && !bad; l++) begin
            if (out_data[l*DW +: DW] !== exp_data[l*DW +: DW] || out_pred[l] !== exp_pred[l]) begin
                errors++; bad = 1'b1;
                $display("FAIL %s lane %0d data %h exp %h pred %b exp %b", req, l,
                         out_data[l*DW +: DW], exp_data[l*DW +: DW], out_pred[l], exp_pred[l]);
            end
        end
    endtask

    // Drive one operation at a falling edge, then check just after the capturing edge.
    task automatic run_op(string req);
        @(negedge clk);
        in_valid = 1'b1;
        model();
        @(posedge clk);
        #1;
        compare(req);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic fill_distinct();
        for (int l = 0; l < LANES; l++)
            in_data[l*DW +: DW] = {32'hA000_0000 + 32'(l), 32'hB000_0000 + 32'(l)};
    endtask

    task automatic fill_random();
        for (int l = 0; l < LANES; l++) begin
            in_data[l*DW +: DW] = {$urandom(), $urandom()};
            in_sel[l*LW +: LW]  = LW'($urandom());
        end
    endtask

    task automatic set_sel_all(int v);
        for (int l = 0; l < LANES; l++) in_sel[l*LW +: LW] = LW'(v);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [LANES*DW-1:0] held_d;
        logic [LANES-1:0]    held_p;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++;
        if (out_valid !== 1'b0 || out_data !== '0 || out_pred !== '0) begin
            errors++;
            $display("FAIL R10 reset valid %b pred %h exp 0 0", out_valid, out_pred);
        end

        // R1 indexed, whole group open
        fill_random(); in_mode = 3'd0; in_bound = 5'd31; run_op("R1 indexed");
        // R2 broadcast from lane 0
        fill_distinct(); set_sel_all(0); in_mode = 3'd0; in_bound = 5'd0; run_op("R2 broadcast lane 0");
        // R1/R7 indexed with a narrow bound
        fill_random(); in_mode = 3'd0; in_bound = 5'd15; run_op("R1 R7 indexed bound 15");
        // R3 shift up by 1 with bound 0, and by 4 with bound 8
        fill_distinct(); set_sel_all(1); in_mode = 3'd1; in_bound = 5'd0; run_op("R3 up 1");
        set_sel_all(4); in_bound = 5'd8; run_op("R3 up 4 bound 8");
        // R4 shift down
        set_sel_all(1); in_mode = 3'd2; in_bound = 5'd31; run_op("R4 down 1");
        set_sel_all(31); run_op("R4 down 31");
        set_sel_all(3); in_bound = 5'd20; run_op("R4 down 3 bound 20");
        // R5 butterfly
        set_sel_all(16); in_mode = 3'd3; in_bound = 5'd31; run_op("R5 xor 16");
        set_sel_all(5); in_bound = 5'd7; run_op("R5 xor 5 bound 7");
        // R6 last-true broadcast
        in_mode = 3'd4; in_vote = 32'h8000_0000; run_op("R6 vote lane 31");
        in_vote = 32'h0000_00F1; run_op("R6 vote top lane 7");
        in_vote = '0; run_op("R6 R7 empty vote");
        // R7 unused mode code
        fill_random(); in_mode = 3'd6; run_op("R7 mode 6");
        in_mode = 3'd5; run_op("R7 mode 5");

        // R9 no strobe: new inputs must not reach the outputs
        held_d = out_data; held_p = out_pred;
        @(negedge clk);
        fill_random(); in_mode = 3'd0; in_bound = 5'd31; in_valid = 1'b0;
        @(posedge clk); #1;
        checks++;
        if (out_valid !== 1'b0 || out_data !== held_d || out_pred !== held_p) begin
            errors++;
            $display("FAIL R9 idle valid %b pred %h exp 0 %h", out_valid, out_pred, held_p);
        end

        // R8 and all modes under random operands with 64-bit words
        for (int n = 0; n < 400; n++) begin
            fill_random();
            in_mode  = 3'($urandom_range(0, 7));
            in_bound = LW'($urandom());
            in_vote  = ($urandom_range(0, 3) == 0) ? '0 : LANES'($urandom() & $urandom());
            run_op("R8 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule